// File: doc/BRIEF.md
# Parallel-Capture Shift Register with Holding Stage

This block pairs an 8-bit holding register with an 8-bit shift register. The holding register takes a snapshot of a shared parallel bus when its capture strobe rises. The shift register either copies the holding register in one step or moves its contents up by one place, taking a new bit at the bottom from one of two serial lines. The shift register's contents drive the parallel bus back through an output-enable control, and its top bit is always driven on a serial output.

All of the block's logic runs on one system clock. The capture strobe and the shift strobe are external pins. The block samples them through a synchronizer and detects their edges there. The other control pins and the bus data pass through the same synchronizer, so every value reaches the decode logic in the same cycle as the strobe it goes with. The parallel copy is level-controlled and is checked on every system cycle. The shift-register clear is asynchronous and takes effect at once. The bus pins are split into an input, an output and a drive enable, and the three-state pad sits outside the block. All pins are plain level signals with no handshake. The block cannot stall its inputs, so a strobe must stay at each level for at least two system cycles before it changes.

Top module: `stor_shift_reg`

## Requirements
- R1: On each rising edge of `st_clk_i` the holding register captures `pbus_i`. Its contents stay the same through shifts, copies and shift-register clears.
- R2: While `ld_n_i` is 0 and `sh_clk_i` is 0, the shift register copies the holding register on every system cycle.
- R3: While `sh_clk_i` is 1, a low `ld_n_i` does not change the shift register.
- R4: A rising edge of `sh_clk_i` with `ld_n_i` = 1 and `sh_en_n_i` = 0 moves bit i to bit i+1 and puts the serial bit into bit 0. `ser_o` always equals bit 7.
- R5: The serial bit comes from `ser0_i` when `sel_i` is 0 and from `ser1_i` when `sel_i` is 1.
- R6: While `sh_en_n_i` is 1, a rising edge of `sh_clk_i` does not shift. The level-controlled copy of R2 still works.
- R7: While `sh_clr_n_i` is 0, the shift register is zero at once, without waiting for a clock edge. The clear overrides both copy and shift.
- R8: `pbus_o` always shows the shift register. `pbus_oe_o` is 1 when `oe_n_i` is 0 and 0 when `oe_n_i` is 1. This output follows `oe_n_i` with no delay.
- R9: A shift, a copy or a capture takes effect on the third rising edge of `clk` after the pin change. This delay is SYNC_STAGES + 1, and SYNC_STAGES is 2 by default.
- R10: While `rst_n` is 0, both the holding register and the shift register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| st_clk_i | input | 1 | Capture strobe for the holding register |
| sh_clk_i | input | 1 | Shift strobe; its level also gates the copy |
| sh_en_n_i | input | 1 | Shift enable, active low |
| ld_n_i | input | 1 | Parallel copy request, active low |
| sh_clr_n_i | input | 1 | Shift-register clear, active low, asynchronous |
| sel_i | input | 1 | Serial line select |
| ser0_i | input | 1 | Serial line 0 |
| ser1_i | input | 1 | Serial line 1 |
| oe_n_i | input | 1 | Bus drive enable, active low |
| pbus_i | input | 8 | Parallel bus as seen at the pins |
| pbus_o | output | 8 | Shift-register contents toward the bus |
| pbus_oe_o | output | 1 | Bus drive enable toward the pad |
| ser_o | output | 1 | Serial output, bit 7 |

## Verification
Shifts, copies and captures become visible after the third rising edge of `clk` that follows the pin change. The clear and the drive enable act within the same time step. The bench changes pins just after a falling edge and holds each strobe level for four cycles. It then reads the results at a falling edge, after the due edge has passed. One dedicated test reads one edge before the due edge and again just after it, which pins down the delay exactly. The clear is checked one nanosecond after it is applied, before any edge of `clk`.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef struct packed {
    logic st_clk;
    logic sh_clk;
    logic sh_en_n;
    logic ld_n;
    logic sel;
    logic ser1;
    logic ser0;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_IDLE = '{st_clk: 1'b0, sh_clk: 1'b0, sh_en_n: 1'b1,
                                  ld_n: 1'b1, sel: 1'b0, ser1: 1'b0, ser0: 1'b0};

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } sh_op_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_det
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift
  import ssr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  sh_op_e       op,
  input  logic         ser,
  input  logic [W-1:0] par,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= par;
        OP_SHIFT: q <= {q[W-2:0], ser};
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/stor_shift_reg.sv
module stor_shift_reg
  import ssr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_clk_i,
  input  logic             sh_clk_i,
  input  logic             sh_en_n_i,
  input  logic             ld_n_i,
  input  logic             sh_clr_n_i,
  input  logic             sel_i,
  input  logic             ser0_i,
  input  logic             ser1_i,
  input  logic             oe_n_i,
  input  logic [WIDTH-1:0] pbus_i,
  output logic [WIDTH-1:0] pbus_o,
  output logic             pbus_oe_o,
  output logic             ser_o
);
  localparam int SYNC_W = WIDTH + CTRL_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {CTRL_IDLE, {WIDTH{1'b0}}};

  ctrl_t             ctrl_raw, ctrl_s;
  logic [WIDTH-1:0]  bus_s;
  logic [SYNC_W-1:0] sync_q;
  logic [1:0]        strobe_lvl, strobe_rise;
  logic [WIDTH-1:0]  hold_q, shreg_q;
  logic              clr_n, ser_bit;
  sh_op_e            op;

  assign ctrl_raw = '{st_clk: st_clk_i, sh_clk: sh_clk_i, sh_en_n: sh_en_n_i,
                      ld_n: ld_n_i, sel: sel_i, ser1: ser1_i, ser0: ser0_i};

  ssr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ctrl_raw, pbus_i}), .q(sync_q)
  );

  assign ctrl_s = ctrl_t'(sync_q[SYNC_W-1:WIDTH]);
  assign bus_s  = sync_q[WIDTH-1:0];

  assign strobe_lvl = {ctrl_s.sh_clk, ctrl_s.st_clk};

  ssr_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(strobe_lvl), .rise(strobe_rise)
  );

  ssr_store #(.W(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .cap(strobe_rise[0]), .d(bus_s), .q(hold_q)
  );

  always_comb begin
    if (!ctrl_s.ld_n && !ctrl_s.sh_clk)
      op = OP_LOAD;
    else if (strobe_rise[1] && ctrl_s.ld_n && !ctrl_s.sh_en_n)
      op = OP_SHIFT;
    else
      op = OP_HOLD;
  end

  assign ser_bit = ctrl_s.sel ? ctrl_s.ser1 : ctrl_s.ser0;
  assign clr_n   = rst_n & sh_clr_n_i;

  ssr_shift #(.W(WIDTH)) u_shift (
    .clk(clk), .clr_n(clr_n), .op(op), .ser(ser_bit), .par(hold_q), .q(shreg_q)
  );

  assign pbus_o    = shreg_q;
  assign ser_o     = shreg_q[WIDTH-1];
  assign pbus_oe_o = ~oe_n_i;
endmodule

// File: rtl/stor_shift_reg_chk.sv
module stor_shift_reg_chk #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sh_clk_i,
  input logic             sh_en_n_i,
  input logic             ld_n_i,
  input logic             sh_clr_n_i,
  input logic [WIDTH-1:0] pbus_o,
  input logic             ser_o
);
  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 7) cyc <= cyc + 3'd1;
  end

  AST_SYS_RESET: assert property (@(posedge clk)
    !rst_n |-> (pbus_o == '0 && !ser_o)); // R10

  AST_CLEAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_clr_n_i |-> (pbus_o == '0 && !ser_o)); // R7

  if (SYNC_STAGES <= 2) begin : g_win
    AST_LOAD_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 5 && sh_clr_n_i && $past(sh_clr_n_i) &&
       sh_clk_i && $past(sh_clk_i,1) && $past(sh_clk_i,2) && $past(sh_clk_i,3) && $past(sh_clk_i,4) &&
       sh_en_n_i && $past(sh_en_n_i,1) && $past(sh_en_n_i,2) && $past(sh_en_n_i,3) && $past(sh_en_n_i,4))
      |-> $stable(pbus_o)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 5 && sh_clr_n_i && $past(sh_clr_n_i) &&
       !sh_clk_i && !$past(sh_clk_i,1) && !$past(sh_clk_i,2) && !$past(sh_clk_i,3) && !$past(sh_clk_i,4) &&
       ld_n_i && $past(ld_n_i,1) && $past(ld_n_i,2) && $past(ld_n_i,3) && $past(ld_n_i,4))
      |-> $stable(pbus_o)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 5 && sh_clr_n_i && $past(sh_clr_n_i) && pbus_o != $past(pbus_o) &&
       ld_n_i && $past(ld_n_i,1) && $past(ld_n_i,2) && $past(ld_n_i,3) && $past(ld_n_i,4))
      |-> (pbus_o[WIDTH-1:1] == $past(pbus_o[WIDTH-2:0]))); // R4
  end
endmodule

bind stor_shift_reg stor_shift_reg_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_clk_i(sh_clk_i), .sh_en_n_i(sh_en_n_i),
  .ld_n_i(ld_n_i), .sh_clr_n_i(sh_clr_n_i), .pbus_o(pbus_o), .ser_o(ser_o)
);

// File: tb/test_stor_shift_reg.sv
`timescale 1ns/1ps
module test_stor_shift_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_clk = 1'b0, sh_clk = 1'b0, sh_en_n = 1'b0, ld_n = 1'b1;
  logic       clr_n = 1'b1, sel = 1'b0, ser0 = 1'b0, ser1 = 1'b0, oe_n = 1'b0;
  logic [7:0] pbus_i = '0;
  logic [7:0] pbus_o;
  logic       pbus_oe, ser_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  stor_shift_reg i_stor_shift_reg (
    .clk(clk), .rst_n(rst_n), .st_clk_i(st_clk), .sh_clk_i(sh_clk),
    .sh_en_n_i(sh_en_n), .ld_n_i(ld_n), .sh_clr_n_i(clr_n), .sel_i(sel),
    .ser0_i(ser0), .ser1_i(ser1), .oe_n_i(oe_n), .pbus_i(pbus_i),
    .pbus_o(pbus_o), .pbus_oe_o(pbus_oe), .ser_o(ser_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic store(logic [7:0] v);
    pbus_i = v; st_clk = 1'b1; wcyc(4);
    st_clk = 1'b0; wcyc(4);
  endtask

  task automatic load();
    ld_n = 1'b0; wcyc(4);
    ld_n = 1'b1; wcyc(4);
  endtask

  task automatic pulse();
    sh_clk = 1'b1; wcyc(4);
    sh_clk = 1'b0; wcyc(4);
  endtask

  initial begin
    logic [7:0] m;
    logic       b;
    wcyc(3);
    chk("R10 reset clears shift reg", pbus_o, 8'h00);
    chk("R8 drive enable with oe_n=0", {7'b0, pbus_oe}, 8'h01);
    rst_n = 1'b1;
    wcyc(2);

    // R1 R2 R4 R5: sweep every stored byte, then eight shifts with mixed sources
    for (int v = 0; v < 256; v++) begin
      store(v[7:0]);
      load();
      chk("R2 copy from holding reg", pbus_o, v[7:0]);
      m = v[7:0];
      for (int k = 0; k < 8; k++) begin
        sel  = k[0] ^ v[0];
        ser0 = ~v[k];
        ser1 = v[7-k];
        b    = sel ? ser1 : ser0;
        m    = {m[6:0], b};
        pulse();
        chk("R4 R5 shift result", pbus_o, m);
        chk("R4 serial out is bit 7", {7'b0, ser_o}, {7'b0, m[7]});
      end
      load();
      chk("R1 holding reg kept while shifting", pbus_o, v[7:0]);
    end

    // R9: exact due edge of a shift
    store(8'h5A); load();
    sel = 1'b0; ser0 = 1'b1;
    sh_clk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not yet shifted after two edges", pbus_o, 8'h5A);
    @(posedge clk); #1;
    chk("R9 shifted on third edge", pbus_o, 8'hB5);
    wcyc(4); sh_clk = 1'b0; wcyc(4);

    // R6: enable high blocks shift, copy still works
    sh_en_n = 1'b1;
    pulse();
    chk("R6 no shift with enable high", pbus_o, 8'hB5);
    store(8'hC3); load();
    chk("R6 copy works with enable high", pbus_o, 8'hC3);

    // R3: copy locked out while shift strobe high
    store(8'h3C);
    sh_clk = 1'b1; wcyc(4);
    ld_n = 1'b0; wcyc(6);
    chk("R3 copy locked with strobe high", pbus_o, 8'hC3);
    ld_n = 1'b1; wcyc(4);
    sh_clk = 1'b0; wcyc(4);
    chk("R3 still unchanged after strobe falls", pbus_o, 8'hC3);
    sh_en_n = 1'b0;

    // R7: asynchronous clear overriding copy and shift
    @(negedge clk); #0.5 clr_n = 1'b0; #1;
    chk("R7 immediate clear", pbus_o, 8'h00);
    wcyc(1);
    ld_n = 1'b0; wcyc(4); ld_n = 1'b1; wcyc(2);
    chk("R7 clear overrides copy", pbus_o, 8'h00);
    ser0 = 1'b1; pulse();
    chk("R7 clear overrides shift", pbus_o, 8'h00);
    clr_n = 1'b1; wcyc(2);
    load();
    chk("R1 holding reg survives clear", pbus_o, 8'h3C);

    // R8: drive enable follows oe_n at once
    oe_n = 1'b1; #1;
    chk("R8 released with oe_n=1", {7'b0, pbus_oe}, 8'h00);
    chk("R8 bus out still shows shift reg", pbus_o, 8'h3C);
    oe_n = 1'b0; #1;
    chk("R8 driven with oe_n=0", {7'b0, pbus_oe}, 8'h01);

    // R10: system reset clears both registers
    rst_n = 1'b0; #1;
    chk("R10 reset clears shift reg", pbus_o, 8'h00);
    wcyc(2); rst_n = 1'b1; wcyc(2);
    load();
    chk("R10 reset cleared holding reg", pbus_o, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule